// File: doc/BRIEF.md
# Two-wire serial EEPROM slave (512 x 8)

This block is the slave side of a two-wire serial memory holding 512 bytes. It samples the bus clock and data lines with a fast system clock. It pulls the data line low through an output-enable and never drives it high. The storage is an internal register array, not real nonvolatile cells.

A master addresses the slave with a start condition and a device byte. That byte carries a fixed type code, two bits that must match the board strap inputs, the ninth array address bit and a read/write flag. In a write, a word-address byte follows, then up to one page of data. The data bytes collect in a 16-byte page buffer. A stop condition copies the pending bytes into the array and starts a self-timed write cycle. During that cycle the slave ignores the bus completely.

In a read, the slave streams bytes from the current pointer. It keeps going while the master acknowledges and stops after a missing acknowledge. To do a random read, the master writes a word address and then issues a repeated start with a read request.

Top module: `eep_2w_slave`

## Requirements
- R1: A start is SDA falling while SCL is high, and a stop is SDA rising while SCL is high. A start in the middle of a byte abandons that byte and begins a new device-byte reception. A stop in the middle of a byte returns the slave to idle.
- R2: After reset, and whenever it is idle, the slave does not drive SDA. It reacts to nothing until it sees a start condition, so a byte clocked in without a start gets no acknowledge.
- R3: The device byte, MSB first, is type code 1010 in bits 7..4, strap_i[1:0] in bits 3..2, array address bit 8 in bit 1, and R/W in bit 0 (1 = read). On a match the slave drives SDA low during the ninth SCL pulse. On a mismatch it gives no acknowledge and stays silent until the next start.
- R4: In a write, bit 1 of the device byte becomes pointer bit 8 and the following word-address byte becomes pointer bits 7..0. The slave acknowledges the word-address byte.
- R5: A stop that follows at least one acknowledged write-data byte commits the page buffer to the array. It also raises busy_o 3 system clocks after SDA rises, for exactly WR_CYCLES clocks. A stop with no data byte starts no write cycle.
- R6: While busy_o is high, the slave never drives SDA and gives no acknowledge to any device byte.
- R7: Each acknowledged write-data byte lands at the current pointer. Then pointer bits 3..0 increment and wrap inside the 16-byte page, while bits 8..4 stay fixed. A byte written more than once in one transaction keeps its last value.
- R8: In a read, each byte goes out MSB first, with a 0 bit driven low and a 1 bit released. After the eighth bit the slave releases SDA. A master acknowledge gets the next byte. A missing acknowledge leaves SDA released until the next start or stop.
- R9: Each byte sent in a read increments the full 9-bit pointer, wrapping from 511 to 0.
- R10: A read starts at the current pointer, and bit 1 of a read device byte is ignored. A repeated start after a write address therefore gives a random read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| scl_i | input | 1 | Bus clock level as seen on the wire |
| sda_i | input | 1 | Bus data level as seen on the wire |
| strap_i | input | 2 | Board strap bits compared with device-byte bits 3..2 |
| sda_oe_o | output | 1 | 1 pulls SDA low, 0 releases it |
| busy_o | output | 1 | High during the self-timed write cycle |

## Verification
Every bus edge reaches a decision 3 system clocks after it happens: two synchronizer flops, then the state register. The bench therefore changes data 2 clocks after SCL falls and samples the slave's SDA at the middle of each SCL high phase, 4 clocks into an 8-clock half period. The busy window is predicted per clock from the clock count at which the bench raised SDA for the stop. It must begin exactly 3 clocks later and last WR_CYCLES clocks, and this prediction is compared with busy_o on every falling edge. Acknowledges and read data are compared with a behavioural memory and pointer model once per byte.

// File: rtl/eep_pkg.sv
package eep_pkg;
  localparam int          EEP_ADDR_W    = 9;
  localparam logic [3:0]  EEP_TYPE_CODE = 4'b1010;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_DEV,
    ST_DEV_ACK,
    ST_ADDR,
    ST_ADDR_ACK,
    ST_WDAT,
    ST_WDAT_ACK,
    ST_RDAT,
    ST_RACK,
    ST_HOLD
  } eep_st_e;
endpackage

// File: rtl/eep_bus_sense.sv
module eep_bus_sense #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  logic [SYNC_STAGES-1:0] scl_sy;
  logic [SYNC_STAGES-1:0] sda_sy;
  logic                   scl_p;
  logic                   sda_p;
  logic                   scl_s;
  logic                   sda_s;

  assign scl_s = scl_sy[SYNC_STAGES-1];
  assign sda_s = sda_sy[SYNC_STAGES-1];

  // Bus lines idle high, so the chain resets to ones.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_sy <= '1;
      sda_sy <= '1;
      scl_p  <= 1'b1;
      sda_p  <= 1'b1;
    end else begin
      scl_sy <= {scl_sy[SYNC_STAGES-2:0], scl_i};
      sda_sy <= {sda_sy[SYNC_STAGES-2:0], sda_i};
      scl_p  <= scl_s;
      sda_p  <= sda_s;
    end
  end

  assign sda_o      = sda_s;
  assign scl_rise_o = scl_s & ~scl_p;
  assign scl_fall_o = ~scl_s & scl_p;
  assign start_o    = scl_s & scl_p & sda_p & ~sda_s;
  assign stop_o     = scl_s & scl_p & ~sda_p & sda_s;
endmodule

// File: rtl/eep_wr_timer.sv
module eep_wr_timer #(
  parameter int CYCLES = 20000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  output logic busy_o
);
  localparam int CW = $clog2(CYCLES + 1);

  logic [CW-1:0] cnt;
  logic [CW-1:0] cnt_n;

  always_comb begin
    cnt_n = cnt;
    if (start_i)          cnt_n = CW'(CYCLES);
    else if (cnt != '0)   cnt_n = cnt - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else        cnt <= cnt_n;
  end

  assign busy_o = (cnt != '0);

  // R5: a commit always opens a busy window on the next clock
  p_busy_on_commit_r5: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> busy_o);
  // R6: no new commit is accepted while a cycle runs
  p_busy_no_retrigger_r6: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |-> !start_i);
endmodule

// File: rtl/eep_array.sv
module eep_array #(
  parameter int ADDR_W = 9,
  parameter int PAGE_W = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     clr_i,
  input  logic                     wr_i,
  input  logic [PAGE_W-1:0]        idx_i,
  input  logic [7:0]               dat_i,
  input  logic                     commit_i,
  input  logic [ADDR_W-PAGE_W-1:0] page_i,
  input  logic [ADDR_W-1:0]        rd_addr_i,
  output logic [7:0]               rd_dat_o,
  output logic                     pend_o
);
  localparam int DEPTH   = 1 << ADDR_W;
  localparam int PAGE_SZ = 1 << PAGE_W;

  logic [7:0]         mem  [DEPTH];
  logic [7:0]         pbuf [PAGE_SZ];
  logic [PAGE_SZ-1:0] valid;
  logic [PAGE_SZ-1:0] valid_n;

  always_comb begin
    valid_n = valid;
    if (clr_i || commit_i) valid_n = '0;
    if (wr_i)              valid_n[idx_i] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) valid <= '0;
    else        valid <= valid_n;
  end

  always_ff @(posedge clk) begin
    if (wr_i) pbuf[idx_i] <= dat_i;
  end

  always_ff @(posedge clk) begin
    if (commit_i) begin
      for (int i = 0; i < PAGE_SZ; i++) begin
        if (valid[i]) mem[{page_i, i[PAGE_W-1:0]}] <= pbuf[i];
      end
    end
  end

  assign rd_dat_o = mem[rd_addr_i];
  assign pend_o   = |valid;

  // R7: an accepted data byte is pending for the commit
  p_page_mark_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_i && !clr_i) |=> pend_o);
endmodule

// File: rtl/eep_2w_slave.sv
module eep_2w_slave
  import eep_pkg::*;
#(
  parameter int PAGE_W      = 4,
  parameter int SYNC_STAGES = 2,
  parameter int WR_CYCLES   = 20000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  input  logic [1:0] strap_i,
  output logic       sda_oe_o,
  output logic       busy_o
);
  localparam int AW   = EEP_ADDR_W;
  localparam int HI_W = AW - PAGE_W;

  logic [1:0]    rst_pipe;
  logic          rst_s_n;
  logic          sda_lvl, scl_rise, scl_fall, start_ev, stop_ev;
  eep_st_e       st, st_n;
  logic [3:0]    cnt, cnt_n;
  logic [7:0]    sh, sh_n, tx, tx_n;
  logic [AW-1:0] ptr, ptr_n;
  logic          is_rd, rd_n, mack, mack_n;
  logic          commit, pg_clr, pg_wr, pend;
  logic [7:0]    rd_dat;
  logic          byte_done, dev_hit, drive;

  // Reset asserts at once and releases on a clock edge.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_s_n = rst_pipe[1];

  eep_bus_sense #(.SYNC_STAGES(SYNC_STAGES)) u_sense (
    .clk(clk), .rst_n(rst_s_n), .scl_i(scl_i), .sda_i(sda_i),
    .sda_o(sda_lvl), .scl_rise_o(scl_rise), .scl_fall_o(scl_fall),
    .start_o(start_ev), .stop_o(stop_ev)
  );

  eep_wr_timer #(.CYCLES(WR_CYCLES)) u_timer (
    .clk(clk), .rst_n(rst_s_n), .start_i(commit), .busy_o(busy_o)
  );

  eep_array #(.ADDR_W(AW), .PAGE_W(PAGE_W)) u_array (
    .clk(clk), .rst_n(rst_s_n), .clr_i(pg_clr), .wr_i(pg_wr),
    .idx_i(ptr[PAGE_W-1:0]), .dat_i(sh), .commit_i(commit),
    .page_i(ptr[AW-1:PAGE_W]), .rd_addr_i(ptr), .rd_dat_o(rd_dat),
    .pend_o(pend)
  );

  assign byte_done = scl_fall && (cnt == 4'd8);
  assign dev_hit   = (sh[7:4] == EEP_TYPE_CODE) && (sh[3:2] == strap_i);

  always_comb begin
    st_n   = st;
    cnt_n  = cnt;
    sh_n   = sh;
    tx_n   = tx;
    ptr_n  = ptr;
    rd_n   = is_rd;
    mack_n = mack;
    commit = 1'b0;
    pg_clr = 1'b0;
    pg_wr  = 1'b0;
    if (stop_ev) begin
      commit = pend;
      st_n   = ST_IDLE;
    end else if (start_ev) begin
      if (!busy_o) begin
        st_n   = ST_DEV;
        cnt_n  = '0;
        pg_clr = 1'b1;
      end
    end else begin
      unique case (st)
        ST_DEV, ST_ADDR, ST_WDAT: begin
          if (scl_rise && (cnt != 4'd8)) begin
            sh_n  = {sh[6:0], sda_lvl};
            cnt_n = cnt + 1'b1;
          end else if (byte_done) begin
            cnt_n = '0;
            if (st == ST_DEV) begin
              if (dev_hit) begin
                rd_n = sh[0];
                if (!sh[0]) ptr_n[AW-1] = sh[1];
                st_n = ST_DEV_ACK;
              end else begin
                st_n = ST_IDLE;
              end
            end else if (st == ST_ADDR) begin
              ptr_n[7:0] = sh;
              st_n       = ST_ADDR_ACK;
            end else begin
              pg_wr                = 1'b1;
              ptr_n[PAGE_W-1:0]    = ptr[PAGE_W-1:0] + 1'b1;
              st_n                 = ST_WDAT_ACK;
            end
          end
        end
        ST_DEV_ACK: begin
          if (scl_fall) begin
            if (is_rd) begin
              st_n  = ST_RDAT;
              tx_n  = rd_dat;
              ptr_n = ptr + 1'b1;
              cnt_n = '0;
            end else begin
              st_n = ST_ADDR;
            end
          end
        end
        ST_ADDR_ACK, ST_WDAT_ACK: begin
          if (scl_fall) st_n = ST_WDAT;
        end
        ST_RDAT: begin
          if (scl_fall) begin
            tx_n  = {tx[6:0], 1'b0};
            cnt_n = cnt + 1'b1;
            if (cnt == 4'd7) st_n = ST_RACK;
          end
        end
        ST_RACK: begin
          if (scl_rise) begin
            mack_n = ~sda_lvl;
          end else if (scl_fall) begin
            if (mack) begin
              st_n  = ST_RDAT;
              tx_n  = rd_dat;
              ptr_n = ptr + 1'b1;
              cnt_n = '0;
            end else begin
              st_n = ST_HOLD;
            end
          end
        end
        ST_IDLE, ST_HOLD: ;
        default: st_n = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      st    <= ST_IDLE;
      cnt   <= '0;
      sh    <= '0;
      tx    <= '0;
      ptr   <= '0;
      is_rd <= 1'b0;
      mack  <= 1'b0;
    end else begin
      st    <= st_n;
      cnt   <= cnt_n;
      sh    <= sh_n;
      tx    <= tx_n;
      ptr   <= ptr_n;
      is_rd <= rd_n;
      mack  <= mack_n;
    end
  end

  always_comb begin
    unique case (st)
      ST_DEV_ACK, ST_ADDR_ACK, ST_WDAT_ACK: drive = 1'b1;
      ST_RDAT:                              drive = ~tx[7];
      default:                              drive = 1'b0;
    endcase
  end
  assign sda_oe_o = drive;

  // R1: an accepted start always begins device-byte reception
  p_start_enters_addr_r1: assert property (@(posedge clk) disable iff (!rst_s_n)
    (start_ev && !busy_o) |=> (st == ST_DEV));
  // R2: idle slave leaves the line alone
  p_idle_quiet_r2: assert property (@(posedge clk) disable iff (!rst_s_n)
    (st == ST_IDLE) |-> !sda_oe_o);
  // R6: write cycle keeps the slave idle and silent
  p_busy_silent_r6: assert property (@(posedge clk) disable iff (!rst_s_n)
    busy_o |-> (!sda_oe_o && (st == ST_IDLE)));
  // R7: page bits of the pointer hold across a data byte
  p_page_fixed_r7: assert property (@(posedge clk) disable iff (!rst_s_n)
    ((st == ST_WDAT) && byte_done && !stop_ev && !start_ev)
      |=> (ptr[AW-1:PAGE_W] == $past(ptr[AW-1:PAGE_W])));
  // R8: after a missing master acknowledge the line stays released
  p_nack_quiet_r8: assert property (@(posedge clk) disable iff (!rst_s_n)
    (st == ST_HOLD) |-> !sda_oe_o);
  // R9: continuing a read advances the full pointer by one
  p_ptr_inc_r9: assert property (@(posedge clk) disable iff (!rst_s_n)
    ((st == ST_RACK) && scl_fall && mack && !stop_ev && !start_ev)
      |=> (ptr == $past(ptr) + 9'd1));
endmodule

// File: tb/tb_eep_2w_slave.sv
`timescale 1ns/1ps
module tb_eep_2w_slave;
  localparam int         WR    = 600;
  localparam int         H     = 8;
  localparam logic [1:0] STRAP = 2'b10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl = 1'b1;
  logic m_low = 1'b0;
  logic sda_oe, busy;
  wire  sda_line;

  always #2 clk = ~clk;
  assign sda_line = !(m_low || sda_oe);

  eep_2w_slave #(.WR_CYCLES(WR)) dut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_line),
    .strap_i(STRAP), .sda_oe_o(sda_oe), .busy_o(busy)
  );

  int     total = 0;
  int     bad = 0;
  longint cyc = 0;
  longint stop_cyc = -1000000;
  bit     model_on = 1'b0;
  bit     finished = 1'b0;
  int     mem_m [512];
  int     ptr_m = 0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  // per-clock reference for the write-cycle window
  always @(negedge clk) begin
    if (model_on) begin
      bit be;
      be = (cyc >= stop_cyc + 3) && (cyc < stop_cyc + 3 + WR);
      chk(busy === be, "R5 busy window", int'(busy), int'(be));
      if (be) chk(!sda_oe, "R6 silent while busy", int'(sda_oe), 0);
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL R2 watchdog act=running exp=finished");
    finish_run();
  end

  task automatic wt(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [7:0] devb(input bit rd, input bit a8,
                                      input logic [3:0] typ = 4'b1010,
                                      input logic [1:0] st = STRAP);
    return {typ, st, a8, rd};
  endfunction

  task automatic start_c();
    scl = 1'b0; wt(H);
    m_low = 1'b0; wt(H);
    scl = 1'b1; wt(H);
    m_low = 1'b1; wt(H);
    scl = 1'b0; wt(H);
  endtask

  task automatic stop_c(input bit commits);
    scl = 1'b0; wt(H);
    m_low = 1'b1; wt(H);
    scl = 1'b1; wt(H);
    m_low = 1'b0;
    if (commits) stop_cyc = cyc;
    wt(H);
  endtask

  task automatic send_bit(input bit b);
    wt(2); m_low = !b; wt(H - 2);
    scl = 1'b1; wt(H);
    scl = 1'b0;
  endtask

  task automatic send_byte(input logic [7:0] v, output bit ack);
    for (int i = 7; i >= 0; i--) send_bit(v[i]);
    wt(2); m_low = 1'b0; wt(H - 2);
    scl = 1'b1; wt(H / 2);
    ack = !sda_line; wt(H / 2);
    scl = 1'b0;
  endtask

  task automatic recv_byte(input bit give_ack, output logic [7:0] b);
    b = '0;
    for (int i = 0; i < 8; i++) begin
      wt(2); m_low = 1'b0; wt(H - 2);
      scl = 1'b1; wt(H / 2);
      b = {b[6:0], sda_line}; wt(H / 2);
      scl = 1'b0;
    end
    wt(2); m_low = give_ack; wt(H - 2);
    scl = 1'b1; wt(H);
    scl = 1'b0; wt(2);
    m_low = 1'b0;
  endtask

  task automatic set_ptr(input int addr);
    bit ack;
    start_c();
    send_byte(devb(1'b0, addr[8]), ack);
    chk(ack, "R3 device ack", int'(ack), 1);
    send_byte(addr[7:0], ack);
    chk(ack, "R4 word address ack", int'(ack), 1);
    ptr_m = addr;
  endtask

  task automatic write_seq(input int addr, input int n, input int first);
    bit ack;
    set_ptr(addr);
    for (int i = 0; i < n; i++) begin
      send_byte(8'(first + i), ack);
      chk(ack, "R7 data ack", int'(ack), 1);
      mem_m[ptr_m] = (first + i) & 255;
      ptr_m = (ptr_m & 'h1F0) | ((ptr_m + 1) & 'hF);
    end
    stop_c(n > 0);
  endtask

  task automatic wait_ready();
    while (cyc < stop_cyc + 3 + WR + 2) @(negedge clk);
  endtask

  task automatic read_cur(input int n, input bit a8, input string tag);
    bit ack;
    logic [7:0] b;
    start_c();
    send_byte(devb(1'b1, a8), ack);
    chk(ack, "R3 read device ack", int'(ack), 1);
    for (int i = 0; i < n; i++) begin
      recv_byte(i < n - 1, b);
      chk(int'(b) == mem_m[ptr_m], tag, int'(b), mem_m[ptr_m]);
      ptr_m = (ptr_m + 1) & 511;
    end
    stop_c(1'b0);
  endtask

  initial begin
    bit ack;
    logic [7:0] b;
    for (int i = 0; i < 512; i++) mem_m[i] = -1;
    wt(5);
    rst_n = 1'b1;
    wt(6);
    chk(busy == 1'b0, "R2 reset busy", int'(busy), 0);
    chk(sda_oe == 1'b0, "R2 reset line released", int'(sda_oe), 0);
    model_on = 1'b1;

    // bits clocked in with no start: no response
    scl = 1'b0; wt(H);
    send_byte(devb(1'b0, 1'b0), ack);
    chk(!ack, "R2 no start no ack", int'(ack), 0);

    // byte write, then an attempt during the write cycle
    write_seq('h123, 1, 'h5C);
    wt(10);
    chk(busy == 1'b1, "R5 busy after data stop", int'(busy), 1);
    start_c();
    send_byte(devb(1'b0, 1'b0), ack);
    chk(!ack, "R6 no ack while busy", int'(ack), 0);
    stop_c(1'b0);
    wait_ready();
    chk(busy == 1'b0, "R5 busy ends", int'(busy), 0);

    // address mismatches
    start_c();
    send_byte(devb(1'b0, 1'b0, 4'b1010, ~STRAP), ack);
    chk(!ack, "R3 strap mismatch", int'(ack), 0);
    stop_c(1'b0);
    start_c();
    send_byte(devb(1'b0, 1'b0, 4'b1011), ack);
    chk(!ack, "R3 type mismatch", int'(ack), 0);
    stop_c(1'b0);

    // random read, read device byte bit 1 opposite to pointer bit 8
    set_ptr('h123);
    read_cur(1, 1'b0, "R10 random read");

    // page write of 18 bytes wraps within the page
    write_seq('h0AE, 18, 'h40);
    wait_ready();
    set_ptr('h0A0);
    read_cur(16, 1'b0, "R7 page contents");

    // sequential read across the top of the array
    write_seq('h1FE, 2, 'h90);
    wait_ready();
    write_seq('h000, 2, 'hA7);
    wait_ready();
    set_ptr('h1FE);
    read_cur(4, 1'b1, "R9 wrap 511 to 0");

    // missing acknowledge releases the line
    set_ptr('h0A0);
    start_c();
    send_byte(devb(1'b1, 1'b0), ack);
    chk(ack, "R8 read device ack", int'(ack), 1);
    recv_byte(1'b0, b);
    chk(int'(b) == mem_m[ptr_m], "R8 single byte", int'(b), mem_m[ptr_m]);
    ptr_m = (ptr_m + 1) & 511;
    for (int i = 0; i < 9; i++) begin
      wt(H);
      scl = 1'b1; wt(H / 2);
      chk(sda_line == 1'b1, "R8 released after nack", int'(sda_line), 1);
      wt(H / 2);
      scl = 1'b0;
    end
    stop_c(1'b0);

    // current-address read continues from the pointer
    read_cur(2, 1'b1, "R10 current address read");

    // start inside a byte restarts reception
    start_c();
    for (int i = 0; i < 4; i++) send_bit(1'b1);
    set_ptr('h123);
    stop_c(1'b0);
    wt(20);
    chk(busy == 1'b0, "R5 no cycle without data", int'(busy), 0);
    read_cur(1, 1'b0, "R1 restart then read");

    // stop inside a byte returns to idle
    start_c();
    send_byte(devb(1'b0, ptr_m[8]), ack);
    chk(ack, "R1 device ack before stop", int'(ack), 1);
    for (int i = 0; i < 3; i++) send_bit(1'b0);
    stop_c(1'b0);
    scl = 1'b0; wt(H);
    send_byte(devb(1'b0, 1'b0), ack);
    chk(!ack, "R1 idle after mid-byte stop", int'(ack), 0);
    wt(20);

    finish_run();
  end
endmodule